// File: doc/BRIEF.md
# NAND Strobe Timing Sequencer

This block turns one bus-cycle request from a command sequencer into correctly shaped NAND interface strobes. Each request names the kind of cycle: command latch, address latch, data write or data read. The block drives chip enable, the write strobe, the read strobe and the two latch-enable lines. Every phase length comes from two timing words that are held static by the surrounding logic. Each field counts controller clock cycles. A field programmed to zero still lasts one cycle.

The block also inserts the waits the flash needs before a read strobe. The first is an array-access wait after the final address of a page read; it ends early when the ready/busy line goes high. The second is a turnaround wait when a read follows a write strobe. The third is a longer of two waits when a read follows an address cycle. The sequencer keeps chip enable asserted across a multi-cycle transaction by leaving the "last" flag low, and closes the transaction with a hold interval by setting it.

Top module: `nand_strobe_timer`

## Requirements
- R1: Out of reset, chip enable, write strobe and read strobe are high (inactive), both latch enables and done are low, and the block is ready for a request.
- R2: Timing word 0 holds six 3-bit fields: CE hold [21:19], CE setup [18:16], write-high [13:11], write-low [10:8], read-high [5:3], read-low [2:0]. Timing word 1 holds the array wait [31:16], the write-to-read turnaround [7:4] and the address-to-read wait [3:0]. Any field that is zero behaves as one cycle.
- R3: A request accepted while chip enable is high first drives chip enable low for CE-setup cycles, then runs any wait, then drops the strobe.
- R4: Kinds 0 (command), 1 (address) and 2 (write data) hold the write strobe low for write-low cycles and then high for write-high cycles, and the read strobe stays high.
- R5: Kind 3 (read data) holds the read strobe low for read-low cycles and then high for read-high cycles, and the write strobe stays high.
- R6: Done is high for exactly one cycle, in the cycle right after the strobe-high phase ends.
- R7: With the last flag set, chip enable stays low for CE-hold cycles after the done cycle and then goes high. With the flag clear, chip enable stays low after done.
- R8: A read that follows an address cycle issued with the arm flag waits for the array-wait count before its strobe. The wait ends early at the first clock edge where ready/busy is sampled high, and it lasts at least one cycle. The arm is used up by that read.
- R9: A read without a pending arm waits the turnaround count if the previous cycle was a write kind. If the previous cycle was an address cycle, it waits the larger of the turnaround and address-to-read counts. A read that follows a read waits nothing.
- R10: The command latch enable is high only during the strobe phases of a kind-0 cycle, and the address latch enable only during those of a kind-1 cycle.
- R11: Ready is high only while no cycle is in progress, and a request is accepted only when ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tim0_i | input | 32 | Strobe and chip-enable timing word |
| tim1_i | input | 32 | Wait timing word |
| req_valid_i | input | 1 | Bus-cycle request |
| req_kind_i | input | 2 | 0 command, 1 address, 2 write data, 3 read data |
| req_arm_i | input | 1 | On an address cycle: arms the array wait for the next read |
| req_last_i | input | 1 | Release chip enable after this cycle |
| req_ready_o | output | 1 | Block idle and able to accept a request |
| rb_ready_i | input | 1 | Flash ready/busy, high when ready |
| done_o | output | 1 | One-cycle completion pulse |
| ce_n_o | output | 1 | Chip enable, active low |
| we_n_o | output | 1 | Write strobe, active low |
| re_n_o | output | 1 | Read strobe, active low |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |

## Verification
The assertions assume the timing words do not change while a cycle is in progress. They also assume that requests are raised only while ready is high, with kind, arm and last valid in the accepting cycle. The bench changes the timing words only between transactions, after chip enable has gone high. It drives each request for a single cycle at a falling edge while ready is high. Ready/busy is driven static for the whole of each transaction, so an array wait is either the full count or exactly one cycle.

// File: rtl/nst_pkg.sv
package nst_pkg;

  localparam int STROBE_W = 3;
  localparam int TURN_W   = 4;
  localparam int ARRAY_W  = 16;
  localparam int N_STROBE = 6;

  // strobe field indices inside timing word 0
  localparam int IX_RP = 0;
  localparam int IX_RH = 1;
  localparam int IX_WP = 2;
  localparam int IX_WH = 3;
  localparam int IX_CS = 4;
  localparam int IX_CH = 5;

  localparam int ARR_LSB = 16;
  localparam int WHR_LSB = 4;
  localparam int AR_LSB  = 0;

  typedef enum logic [1:0] {
    K_CMD   = 2'd0,
    K_ADDR  = 2'd1,
    K_WDATA = 2'd2,
    K_RDATA = 2'd3
  } bus_kind_e;

  typedef enum logic [3:0] {
    PH_OFF, PH_ON, PH_SETUP, PH_GAP, PH_ARRAY, PH_LOW, PH_HIGH, PH_DONE, PH_HOLD
  } phase_e;

  function automatic int strobe_lsb(input int idx);
    case (idx)
      IX_RP:   return 0;
      IX_RH:   return 3;
      IX_WP:   return 8;
      IX_WH:   return 11;
      IX_CS:   return 16;
      default: return 19;
    endcase
  endfunction

  function automatic logic [STROBE_W-1:0] min1_s(input logic [STROBE_W-1:0] v);
    return (v == '0) ? STROBE_W'(1) : v;
  endfunction

  function automatic logic [TURN_W-1:0] min1_t(input logic [TURN_W-1:0] v);
    return (v == '0) ? TURN_W'(1) : v;
  endfunction

  function automatic logic [ARRAY_W-1:0] min1_a(input logic [ARRAY_W-1:0] v);
    return (v == '0) ? ARRAY_W'(1) : v;
  endfunction

  // pre-strobe wait for a read with no array wait pending
  function automatic logic [TURN_W-1:0] turn_gap(input logic after_wr, input logic after_addr,
                                                 input logic [TURN_W-1:0] whr,
                                                 input logic [TURN_W-1:0] ar);
    logic [TURN_W-1:0] a, w;
    a = after_addr ? ar  : '0;
    w = after_wr   ? whr : '0;
    return (a > w) ? a : w;
  endfunction

endpackage

// File: rtl/nst_field_unpack.sv
module nst_field_unpack
  import nst_pkg::*;
(
  input  logic [31:0]                        tim0_i,
  input  logic [31:0]                        tim1_i,
  output logic [N_STROBE-1:0][STROBE_W-1:0]  strobe_o,
  output logic [ARRAY_W-1:0]                 arr_o,
  output logic [TURN_W-1:0]                  whr_o,
  output logic [TURN_W-1:0]                  ar_o
);

  for (genvar i = 0; i < N_STROBE; i++) begin : g_strobe
    localparam int LSB = strobe_lsb(i);
    assign strobe_o[i] = min1_s(tim0_i[LSB +: STROBE_W]);
  end

  assign arr_o = min1_a(tim1_i[ARR_LSB +: ARRAY_W]);
  assign whr_o = min1_t(tim1_i[WHR_LSB +: TURN_W]);
  assign ar_o  = min1_t(tim1_i[AR_LSB +: TURN_W]);

  logic unused_fields;
  assign unused_fields = ^{tim0_i[31:22], tim0_i[15:14], tim0_i[7:6], tim1_i[15:8]};

endmodule

// File: rtl/nst_wait_select.sv
module nst_wait_select
  import nst_pkg::*;
(
  input  logic [1:0]        kind_i,
  input  logic              armed_i,
  input  logic              prev_wr_i,
  input  logic              prev_addr_i,
  input  logic [TURN_W-1:0] whr_i,
  input  logic [TURN_W-1:0] ar_i,
  output logic              use_array_o,
  output logic [TURN_W-1:0] gap_o
);

  logic is_read;
  assign is_read     = (kind_i == K_RDATA);
  assign use_array_o = is_read && armed_i;
  assign gap_o       = (is_read && !armed_i) ? turn_gap(prev_wr_i, prev_addr_i, whr_i, ar_i) : '0;

endmodule

// File: rtl/nst_phase_counter.sv
module nst_phase_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/nand_strobe_timer.sv
module nand_strobe_timer
  import nst_pkg::*;
#(
  parameter int CNT_W = nst_pkg::ARRAY_W
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] tim0_i,
  input  logic [31:0] tim1_i,
  input  logic        req_valid_i,
  input  logic [1:0]  req_kind_i,
  input  logic        req_arm_i,
  input  logic        req_last_i,
  output logic        req_ready_o,
  input  logic        rb_ready_i,
  output logic        done_o,
  output logic        ce_n_o,
  output logic        we_n_o,
  output logic        re_n_o,
  output logic        cle_o,
  output logic        ale_o
);

  logic [N_STROBE-1:0][STROBE_W-1:0] strobe;
  logic [ARRAY_W-1:0] t_arr;
  logic [TURN_W-1:0]  t_whr, t_ar;

  nst_field_unpack u_unpack (
    .tim0_i(tim0_i), .tim1_i(tim1_i),
    .strobe_o(strobe), .arr_o(t_arr), .whr_o(t_whr), .ar_o(t_ar)
  );

  phase_e     phase_q, phase_d;
  logic [1:0] kind_q;
  logic       arm_q, last_q, armed_q, prev_wr_q, prev_addr_q;

  logic idle, accept_evt;
  assign idle       = (phase_q == PH_OFF) || (phase_q == PH_ON);
  assign accept_evt = idle && req_valid_i;

  logic [1:0] k_sel;
  assign k_sel = idle ? req_kind_i : kind_q;

  logic              use_array;
  logic [TURN_W-1:0] gap;

  nst_wait_select u_wait (
    .kind_i(k_sel), .armed_i(armed_q), .prev_wr_i(prev_wr_q), .prev_addr_i(prev_addr_q),
    .whr_i(t_whr), .ar_i(t_ar), .use_array_o(use_array), .gap_o(gap)
  );

  logic [CNT_W-1:0] low_m1, high_m1, cs_m1, ch_m1, arr_m1, gap_m1;
  assign low_m1  = CNT_W'((k_sel  == K_RDATA) ? strobe[IX_RP] : strobe[IX_WP]) - 1'b1;
  assign high_m1 = CNT_W'((kind_q == K_RDATA) ? strobe[IX_RH] : strobe[IX_WH]) - 1'b1;
  assign cs_m1   = CNT_W'(strobe[IX_CS]) - 1'b1;
  assign ch_m1   = CNT_W'(strobe[IX_CH]) - 1'b1;
  assign arr_m1  = CNT_W'(t_arr) - 1'b1;
  assign gap_m1  = CNT_W'(gap) - 1'b1;

  // phase entered once chip enable is set up
  phase_e           ew_phase;
  logic [CNT_W-1:0] ew_val;
  always_comb begin
    if (use_array) begin
      ew_phase = PH_ARRAY; ew_val = arr_m1;
    end else if (gap != '0) begin
      ew_phase = PH_GAP;   ew_val = gap_m1;
    end else begin
      ew_phase = PH_LOW;   ew_val = low_m1;
    end
  end

  logic             cnt_zero, load;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    phase_d  = phase_q;
    load     = 1'b0;
    load_val = '0;
    unique case (phase_q)
      PH_OFF:   if (req_valid_i) begin phase_d = PH_SETUP; load = 1'b1; load_val = cs_m1; end
      PH_ON:    if (req_valid_i) begin phase_d = ew_phase; load = 1'b1; load_val = ew_val; end
      PH_SETUP: if (cnt_zero)    begin phase_d = ew_phase; load = 1'b1; load_val = ew_val; end
      PH_GAP:   if (cnt_zero)    begin phase_d = PH_LOW;   load = 1'b1; load_val = low_m1; end
      PH_ARRAY: if (cnt_zero || rb_ready_i) begin
                  phase_d = PH_LOW; load = 1'b1; load_val = low_m1;
                end
      PH_LOW:   if (cnt_zero)    begin phase_d = PH_HIGH;  load = 1'b1; load_val = high_m1; end
      PH_HIGH:  if (cnt_zero)    phase_d = PH_DONE;
      PH_DONE:  if (last_q)      begin phase_d = PH_HOLD;  load = 1'b1; load_val = ch_m1; end
                else             phase_d = PH_ON;
      PH_HOLD:  if (cnt_zero)    phase_d = PH_OFF;
      default:  phase_d = PH_OFF;
    endcase
  end

  nst_phase_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(load), .load_val_i(load_val), .zero_o(cnt_zero)
  );

  logic array_enter;
  assign array_enter = (phase_d == PH_ARRAY) && (phase_q != PH_ARRAY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_OFF;
      kind_q      <= K_CMD;
      arm_q       <= 1'b0;
      last_q      <= 1'b0;
      armed_q     <= 1'b0;
      prev_wr_q   <= 1'b0;
      prev_addr_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (accept_evt) begin
        kind_q <= req_kind_i;
        arm_q  <= req_arm_i;
        last_q <= req_last_i;
      end
      if (array_enter) armed_q <= 1'b0;
      if (phase_q == PH_DONE) begin
        prev_wr_q   <= (kind_q != K_RDATA);
        prev_addr_q <= (kind_q == K_ADDR);
        if (kind_q == K_ADDR && arm_q) armed_q <= 1'b1;
      end
    end
  end

  logic strobe_phase, strobe_low;
  assign strobe_phase = (phase_q == PH_LOW) || (phase_q == PH_HIGH);

  assign req_ready_o = idle;
  assign done_o      = (phase_q == PH_DONE);
  assign ce_n_o      = (phase_q == PH_OFF);
  assign we_n_o      = !((phase_q == PH_LOW) && (kind_q != K_RDATA));
  assign re_n_o      = !((phase_q == PH_LOW) && (kind_q == K_RDATA));
  assign cle_o       = strobe_phase && (kind_q == K_CMD);
  assign ale_o       = strobe_phase && (kind_q == K_ADDR);
  assign strobe_low  = !we_n_o || !re_n_o;

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n_o && !re_n_o));

  // R3
  ce_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_low |-> !ce_n_o);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R11
  accept_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=> (!ce_n_o && !req_ready_o));

  // R7
  ce_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce_n_o) |-> $past(!done_o && we_n_o && re_n_o));

endmodule

// File: tb/nand_strobe_timer_tb.sv
`timescale 1ns/1ps
module nand_strobe_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tim0 = '0, tim1 = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = '0;
  logic        req_arm = 1'b0, req_last = 1'b0;
  logic        rb_ready = 1'b0;
  logic        req_ready, done, ce_n, we_n, re_n, cle, ale;

  always #10 clk = ~clk;

  nand_strobe_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tim0_i(tim0), .tim1_i(tim1),
    .req_valid_i(req_valid), .req_kind_i(req_kind), .req_arm_i(req_arm),
    .req_last_i(req_last), .req_ready_o(req_ready), .rb_ready_i(rb_ready),
    .done_o(done), .ce_n_o(ce_n), .we_n_o(we_n), .re_n_o(re_n),
    .cle_o(cle), .ale_o(ale)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  // programmed field values (raw)
  int f_cs, f_ch, f_wp, f_wh, f_rp, f_rh, f_arr, f_whr, f_ar;
  // bench model of history
  bit m_armed = 0, m_prev_wr = 0, m_prev_addr = 0;

  function automatic int cyc(input int raw);
    return (raw > 0) ? raw : 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic program_fields();
    tim0 = (f_ch << 19) | (f_cs << 16) | (f_wh << 11) | (f_wp << 8) | (f_rh << 3) | f_rp;
    tim1 = (f_arr << 16) | (f_whr << 4) | f_ar;
  endtask

  task automatic run_op(input int kind, input bit arm, input bit last);
    int exp_pre, exp_low, exp_high, a, w;
    int n_pre, n_low, n_high, n_hold, guard, bad_str, bad_ctl;
    bit got_done, rdy_first;
    @(negedge clk);
    exp_pre = ce_n ? cyc(f_cs) : 0;
    if (kind == 3) begin
      if (m_armed) begin
        exp_pre += rb_ready ? 1 : cyc(f_arr);
        m_armed = 0;
      end else begin
        a = m_prev_addr ? cyc(f_ar) : 0;
        w = m_prev_wr ? cyc(f_whr) : 0;
        exp_pre += (a > w) ? a : w;
      end
      exp_low = cyc(f_rp); exp_high = cyc(f_rh);
    end else begin
      exp_low = cyc(f_wp); exp_high = cyc(f_wh);
    end
    m_prev_wr = (kind != 3);
    m_prev_addr = (kind == 1);
    if (kind == 1 && arm) m_armed = 1;

    req_valid = 1'b1; req_kind = kind[1:0]; req_arm = arm; req_last = last;
    @(negedge clk);
    req_valid = 1'b0;
    rdy_first = req_ready;
    n_pre = 0; n_low = 0; n_high = 0; guard = 0; bad_str = 0; bad_ctl = 0; got_done = 0;
    while (!got_done && guard < 2000) begin
      if (done) got_done = 1;
      else if (!we_n || !re_n) begin
        n_low++;
        if ((kind == 3) ? !we_n : !re_n) bad_str++;
        if (cle != (kind == 0) || ale != (kind == 1)) bad_ctl++;
      end else if (n_low == 0) begin
        n_pre++;
        if (cle || ale) bad_ctl++;
      end else begin
        n_high++;
        if (cle != (kind == 0) || ale != (kind == 1)) bad_ctl++;
      end
      if (!got_done) @(negedge clk);
      guard++;
    end
    check(rdy_first == 0, "R11 busy after accept", rdy_first, 0);
    check(got_done, "R6 done seen", got_done, 1);
    // R3 R8 R9: cycles before the strobe falls
    check(n_pre == exp_pre, (kind == 3) ? "R8/R9 pre-strobe wait" : "R3 pre-strobe", n_pre, exp_pre);
    check(n_low == exp_low, (kind == 3) ? "R5 read low" : "R4 write low", n_low, exp_low);
    check(n_high == exp_high, (kind == 3) ? "R5 read high" : "R4 write high", n_high, exp_high);
    check(bad_str == 0, "R4 R5 wrong strobe", bad_str, 0);
    check(bad_ctl == 0, "R10 latch enables", bad_ctl, 0);
    @(negedge clk);
    check(!done, "R6 single done", done, 0);
    if (last) begin
      n_hold = 0; guard = 0;
      while (!ce_n && guard < 100) begin n_hold++; guard++; @(negedge clk); end
      // R7
      check(n_hold == cyc(f_ch), "R7 ce hold", n_hold, cyc(f_ch));
      check(req_ready, "R11 ready when idle", req_ready, 1);
    end else begin
      check(!ce_n && req_ready, "R7 ce kept low", ce_n, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(ce_n && we_n && re_n, "R1 strobes idle", {ce_n, we_n, re_n}, 7);
    check(!cle && !ale && !done, "R1 controls low", {cle, ale, done}, 0);
    check(req_ready, "R1 ready", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    for (int v = 0; v < 8; v++) begin
      // R2: fields sweep including zero values
      f_cs = v; f_wp = (v + 1) % 8; f_wh = (v + 3) % 8; f_rp = (v + 5) % 8;
      f_rh = (v + 2) % 8; f_ch = (v + 6) % 8;
      f_whr = (2 * v) % 16; f_ar = (15 - 3 * v) & 15; f_arr = 3 * v;
      program_fields();
      rb_ready = 1'b0;
      run_op(0, 0, 0); run_op(1, 1, 0); run_op(3, 0, 0); run_op(3, 0, 1);
      run_op(2, 0, 1);
      run_op(0, 0, 0); run_op(3, 0, 1);
      run_op(0, 0, 0); run_op(1, 0, 0); run_op(3, 0, 1);
      // R8: ready/busy already high ends the array wait early
      rb_ready = 1'b1;
      run_op(0, 0, 0); run_op(1, 1, 0); run_op(3, 0, 1);
      rb_ready = 1'b0;
    end
    // R8: long array wait with busy held low
    f_arr = 300; program_fields();
    run_op(0, 0, 0); run_op(1, 1, 0); run_op(2, 0, 0); run_op(3, 0, 1);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule